// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes a stack-oriented instruction stream. It holds an internal operand stack. Its arithmetic instructions name no operands: both sources come from the two uppermost stack entries. Only two instructions touch the outside world. A push loads a word from a word-addressed data memory onto the stack. A pop stores the uppermost entry to memory and removes it. The binary operations are add, subtract, AND and OR. Each one removes the uppermost entry and overwrites the entry below it with the result.

Instructions arrive one at a time over a valid/ready handshake. Each carries a 3-bit opcode and, for push and pop, a memory address. The memory port is synchronous. A read returns its data on the cycle after the request, so the unit drops ready for that one cycle. Illegal stack use is caught and recorded. An instruction that would read missing entries sets a sticky underflow flag. A push onto a full stack sets a sticky overflow flag. In both cases the stack is left as it was.

The controller has two states. RUN accepts instructions and has ready high. FETCH waits for the memory word and has ready low. The transition RUN to FETCH happens when a push is accepted with room on the stack. The transition FETCH to RUN is unconditional after one cycle, and the returned word is written onto the stack in that cycle. Every other accepted instruction leaves the controller in RUN.

Top module: `stack_core`

## Requirements
- R1: After reset, in_ready is high, both flags are low, neither memory enable is asserted and the stack is empty.
- R2: An accepted push (opcode 0) with room on the stack asserts mem_rd_en with mem_addr equal to the instruction address in the acceptance cycle. The word that memory returns on the next cycle becomes the new top entry.
- R3: An accepted pop (opcode 1) on a non-empty stack asserts mem_wr_en in the acceptance cycle, with mem_addr equal to the instruction address and mem_wdata equal to the top entry. That entry is then removed.
- R4: Add (opcode 2), AND (opcode 4) and OR (opcode 5) remove the top entry and replace the entry beneath it with the sum or bitwise result, so the depth drops by one.
- R5: Subtract (opcode 3) yields the second entry minus the top entry.
- R6: The sequence push A, push B, add, pop C leaves A+B in location C and returns the stack to its starting depth.
- R7: A binary operation with fewer than two entries, or a pop on an empty stack, sets the sticky underflow flag. The stack is not changed and no memory write occurs.
- R8: A push onto a full stack (DEPTH entries) sets the sticky overflow flag. No memory read occurs, the push is discarded and in_ready stays high.
- R9: Entries leave the stack in the reverse of the order they entered, across the full depth.
- R10: Opcodes 6 and 7 are accepted and have no effect on the stack, memory or flags.
- R11: in_ready is low for exactly the one cycle after an accepted push. No instruction is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_op | input | 3 | Opcode |
| in_addr | input | AW | Memory address for push and pop |
| mem_addr | output | AW | Memory word address |
| mem_rd_en | output | 1 | Memory read request, data due next cycle |
| mem_rdata | input | W | Memory read data |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | W | Memory write data |
| ovf_flag | output | 1 | Sticky overflow indication |
| unf_flag | output | 1 | Sticky underflow indication |

## Verification
The memory enables, address and write data are combinational from the offered instruction. They are due in the acceptance cycle itself. in_ready falls one edge after an accepted push, and the pushed word is on the stack from the edge after that. The flags are registered and appear one edge after the offending instruction. The bench drives each instruction half a period before the rising edge and compares the design with its queue-based reference one time unit later. The reference model compares the flags it held before the instruction now being offered, so every comparison lines up with the edge on which the design is due to change. Arithmetic results are checked through later pops into bench memory.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic {
        ST_RUN,
        ST_FETCH
    } state_e;

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] res
);

    always_comb begin
        unique case (op)
            OP_ADD:  res = lhs + rhs;
            OP_SUB:  res = lhs - rhs;
            OP_AND:  res = lhs & rhs;
            OP_OR:   res = lhs | rhs;
            default: res = lhs;
        endcase
    end

endmodule

// File: rtl/stk_store.sv
module stk_store #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic [W-1:0]  push_data,
    input  logic          pop_en,
    input  logic          reduce_en,
    input  logic [W-1:0]  reduce_data,
    output logic [W-1:0]  top,
    output logic [W-1:0]  second,
    output logic [CW-1:0] count
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  ent [DEPTH];
    logic [CW-1:0] top_ix;
    logic [CW-1:0] sec_ix;

    assign top_ix = count - CW'(1);
    assign sec_ix = count - CW'(2);
    assign top    = ent[IW'(top_ix)];
    assign second = ent[IW'(sec_ix)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (push_en) begin
            count <= count + CW'(1);
        end else if (pop_en || reduce_en) begin
            count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_en) begin
            ent[IW'(count)] <= push_data;
        end else if (reduce_en) begin
            ent[IW'(sec_ix)] <= reduce_data;
        end
    end

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R2
    push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> count == $past(count) + CW'(1));

    // R4
    reduce_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reduce_en |=> count == $past(count) - CW'(1));

    // R7
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> count != '0);

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  op_e           in_op,
    input  logic [CW-1:0] count,
    output logic          in_ready,
    output logic          rd_en,
    output logic          wr_en,
    output logic          push_en,
    output logic          pop_en,
    output logic          reduce_en,
    output logic          ovf_flag,
    output logic          unf_flag
);

    state_e state, state_nx;
    logic   take;
    logic   full, has_one, has_two;
    logic   ovf_set, unf_set;

    assign full    = (count == CW'(DEPTH));
    assign has_one = (count != '0);
    assign has_two = (count > CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            state    <= state_nx;
            ovf_flag <= ovf_flag | ovf_set;
            unf_flag <= unf_flag | unf_set;
        end
    end

    always_comb begin
        state_nx  = state;
        in_ready  = 1'b0;
        rd_en     = 1'b0;
        wr_en     = 1'b0;
        push_en   = 1'b0;
        pop_en    = 1'b0;
        reduce_en = 1'b0;
        ovf_set   = 1'b0;
        unf_set   = 1'b0;
        take      = 1'b0;
        unique case (state)
            ST_FETCH: begin
                push_en  = 1'b1;
                state_nx = ST_RUN;
            end
            ST_RUN: begin
                in_ready = 1'b1;
                take     = in_valid;
                if (take) begin
                    unique case (in_op)
                        OP_PUSH: begin
                            if (full) begin
                                ovf_set = 1'b1;
                            end else begin
                                rd_en    = 1'b1;
                                state_nx = ST_FETCH;
                            end
                        end
                        OP_POP: begin
                            if (has_one) begin
                                wr_en  = 1'b1;
                                pop_en = 1'b1;
                            end else begin
                                unf_set = 1'b1;
                            end
                        end
                        OP_ADD, OP_SUB, OP_AND, OP_OR: begin
                            if (has_two) reduce_en = 1'b1;
                            else         unf_set   = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // R11
    fetch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (state == ST_FETCH) && !in_ready);

    // R11
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> in_ready);

    // R3
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R7
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |=> unf_flag);

endmodule

// File: rtl/stack_core.sv
module stack_core
    import stk_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [2:0]    in_op,
    input  logic [AW-1:0] in_addr,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd_en,
    input  logic [W-1:0]  mem_rdata,
    output logic          mem_wr_en,
    output logic [W-1:0]  mem_wdata,
    output logic          ovf_flag,
    output logic          unf_flag
);

    localparam int CW = $clog2(DEPTH + 1);

    op_e           op;
    logic [CW-1:0] count;
    logic [W-1:0]  top, second, alu_res;
    logic          push_en, pop_en, reduce_en;

    assign op        = op_e'(in_op);
    assign mem_addr  = in_addr;
    assign mem_wdata = top;

    stk_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (op),
        .count     (count),
        .in_ready  (in_ready),
        .rd_en     (mem_rd_en),
        .wr_en     (mem_wr_en),
        .push_en   (push_en),
        .pop_en    (pop_en),
        .reduce_en (reduce_en),
        .ovf_flag  (ovf_flag),
        .unf_flag  (unf_flag)
    );

    stk_alu #(.W(W)) u_alu (
        .op  (op),
        .lhs (second),
        .rhs (top),
        .res (alu_res)
    );

    stk_store #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_en     (push_en),
        .push_data   (mem_rdata),
        .pop_en      (pop_en),
        .reduce_en   (reduce_en),
        .reduce_data (alu_res),
        .top         (top),
        .second      (second),
        .count       (count)
    );

endmodule

// File: tb/test_stack_core.sv
module test_stack_core;

    localparam int W     = 32;
    localparam int DEPTH = 8;
    localparam int AW    = 4;
    localparam int NLOC  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [2:0]    in_op = 3'd0;
    logic [AW-1:0] in_addr = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_en, mem_wr_en;
    logic [W-1:0]  mem_rdata = '0;
    logic [W-1:0]  mem_wdata;
    logic          ovf_flag, unf_flag;

    logic [W-1:0]  memm [NLOC];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [W-1:0] q[$];
    bit           m_fetch = 0;
    logic [W-1:0] m_pend  = '0;
    bit           m_ovf = 0, m_unf = 0;

    always #2.5 clk = ~clk;

    stack_core #(.W(W), .DEPTH(DEPTH), .AW(AW)) i_stack_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_addr(in_addr), .mem_addr(mem_addr),
        .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    always @(posedge clk) begin
        if (mem_wr_en) memm[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= memm[mem_addr];
    end

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock: drive, compare against the model, advance the model.
    // Returns 1 when the offered instruction is taken.
    task automatic step(input bit v, input logic [2:0] op,
                        input logic [AW-1:0] a, output bit taken);
        bit e_rd, e_wr;
        logic [W-1:0] b;
        @(negedge clk);
        in_valid = v; in_op = op; in_addr = a;
        #1;
        e_rd = 0; e_wr = 0; taken = 0;
        chk("R7", "unf_flag", W'(unf_flag), W'(m_unf));
        chk("R8", "ovf_flag", W'(ovf_flag), W'(m_ovf));
        if (m_fetch) begin
            chk("R11", "in_ready", W'(in_ready), 0);
            q.push_back(m_pend);
            m_fetch = 0;
        end else begin
            chk("R11", "in_ready", W'(in_ready), 1);
            if (v) begin
                taken = 1;
                case (op)
                    3'd0: if (q.size() == DEPTH) m_ovf = 1;
                          else begin e_rd = 1; m_pend = memm[a]; m_fetch = 1; end
                    3'd1: if (q.size() == 0) m_unf = 1;
                          else begin
                              e_wr = 1;
                              chk("R3", "mem_wdata", mem_wdata, q[$]);
                              chk("R3", "mem_addr", W'(mem_addr), W'(a));
                              void'(q.pop_back());
                          end
                    3'd2, 3'd3, 3'd4, 3'd5:
                          if (q.size() < 2) m_unf = 1;
                          else begin
                              b = q.pop_back();
                              case (op)
                                  3'd2: q[$] = q[$] + b;
                                  3'd3: q[$] = q[$] - b;
                                  3'd4: q[$] = q[$] & b;
                                  default: q[$] = q[$] | b;
                              endcase
                          end
                    default: ;
                endcase
                if (e_rd) chk("R2", "mem_addr", W'(mem_addr), W'(a));
            end
        end
        chk("R2", "mem_rd_en", W'(mem_rd_en), W'(e_rd));
        chk("R3", "mem_wr_en", W'(mem_wr_en), W'(e_wr));
    endtask

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a);
        bit t;
        t = 0;
        while (!t) step(1, op, a, t);
    endtask

    task automatic idle();
        bit t;
        step(0, 3'd0, '0, t);
    endtask

    initial begin
        for (int i = 0; i < NLOC; i++) memm[i] = 32'h1000_0000 + i * 32'h0101_0011;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "in_ready", W'(in_ready), 1);
        chk("R1", "flags", W'({ovf_flag, unf_flag}), 0);
        chk("R1", "enables", W'({mem_rd_en, mem_wr_en}), 0);
        rst_n = 1'b1;
        idle();

        // R6: push A, push B, add, pop C
        memm[1] = 32'd1234; memm[2] = 32'hFFFF_FFF0;
        issue(3'd0, 4'd1); issue(3'd0, 4'd2); issue(3'd2, '0); issue(3'd1, 4'd3);
        idle(); idle();
        chk("R6", "sum in C", memm[3], 32'd1234 + 32'hFFFF_FFF0);
        chk("R6", "depth restored", W'(q.size()), 0);

        // R5: subtract order
        memm[5] = 32'd100; memm[6] = 32'd30;
        issue(3'd0, 4'd5); issue(3'd0, 4'd6); issue(3'd3, '0); issue(3'd1, 4'd7);
        idle(); idle();
        chk("R5", "second minus top", memm[7], 32'd70);

        // R4: AND then OR
        memm[1] = 32'hF0F0_00FF; memm[2] = 32'h0FF0_0F0F; memm[3] = 32'h0000_3000;
        issue(3'd0, 4'd1); issue(3'd0, 4'd2); issue(3'd4, '0);
        issue(3'd0, 4'd3); issue(3'd5, '0); issue(3'd1, 4'd4);
        idle(); idle();
        chk("R4", "and/or", memm[4], (32'hF0F0_00FF & 32'h0FF0_0F0F) | 32'h0000_3000);

        // R10: reserved opcodes leave a single entry alone
        memm[9] = 32'hCAFE_0009;
        issue(3'd0, 4'd9); issue(3'd6, 4'd2); issue(3'd7, 4'd3); issue(3'd1, 4'd10);
        idle(); idle();
        chk("R10", "entry untouched", memm[10], 32'hCAFE_0009);
        chk("R10", "no flag", W'({ovf_flag, unf_flag}), 0);

        // R9 / R8: fill, overflow, drain in reverse
        for (int i = 0; i < NLOC; i++) memm[i] = 32'hA000_0000 + i;
        for (int i = 0; i < DEPTH; i++) issue(3'd0, AW'(i));
        issue(3'd0, 4'd15);
        idle();
        chk("R8", "overflow flag", W'(ovf_flag), 1);
        for (int i = 0; i < DEPTH; i++) issue(3'd1, AW'(8 + i));
        idle(); idle();
        for (int i = 0; i < DEPTH; i++)
            chk("R9", "reverse order", memm[8 + i], 32'hA000_0000 + W'(DEPTH - 1 - i));

        // R7: pop on empty, then add with one entry leaves that entry
        memm[0] = 32'h5555_0000;
        issue(3'd1, 4'd1);
        idle();
        chk("R7", "underflow on empty pop", W'(unf_flag), 1);
        chk("R7", "no write on empty pop", memm[1], 32'hA000_0001);
        issue(3'd0, 4'd0); issue(3'd2, '0); issue(3'd1, 4'd2);
        idle(); idle();
        chk("R7", "entry kept after bad add", memm[2], 32'h5555_0000);
        chk("R7", "flag still set", W'(unf_flag), 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule